// File: doc/BRIEF.md
# Repeated String Port-Input Sequencer

This block performs a string input operation for a processor execution unit. After a start pulse it reads one item from a 16-bit I/O port space and stores it to memory at a destination pointer. It then moves that pointer by the item size. In repeat mode it keeps going, lowering a count after every item, until the count is exhausted. The item size comes from the opcode and the operand-size attribute. The address-size attribute chooses between a 16-bit and a 32-bit pointer. A direction input makes the pointer climb or fall.

Each item goes through two steps. The first is a read handshake on the I/O side. Only after that read has been acknowledged does the block start a write handshake on the memory side. The updated pointer and count are held on output registers and are final in the cycle that `done` pulses. Decode, segment translation, privilege checks and faults are handled elsewhere. The block modifies no status flag.

Top module: `strin_seq`

## Requirements
- R1: After synchronous reset, `io_rd_req`, `mem_wr_req`, `busy` and `done` are 0, and `ptr_out` and `cnt_out` are 0.
- R2: Item size is decoded from `opcode` bit 0 and `opsz32`. If bit 0 is 0 (opcode 0x6C), the item is 1 byte. If bit 0 is 1 (opcode 0x6D), the item is 2 bytes when `opsz32`=0 and 4 bytes when `opsz32`=1. `mem_be` is 4'b0001, 4'b0011 or 4'b1111 for these sizes.
- R3: `io_rd_req` stays high until `io_rd_ack` is seen. `io_addr` is the `port_addr` captured at start.
- R4: `mem_wr_req` is raised only after the item's read has been acknowledged. It is never high together with `io_rd_req`, and it stays high until `mem_wr_ack`. `mem_wdata` is the read data with every byte above the item size forced to zero.
- R5: With `adsz32`=1, `mem_addr` is the full 32-bit pointer. With `adsz32`=0, `mem_addr` is the low 16 bits of the pointer, zero-extended.
- R6: After each write acknowledge, the pointer moves by the item size. It increases when `dir_down`=0 and decreases when `dir_down`=1.
- R7: With `adsz32`=0, only the low 16 bits of the pointer change, and they wrap modulo 65536 while the upper 16 bits keep their value. With `adsz32`=1, the pointer wraps modulo 2^32.
- R8: With `rep_en`=0, exactly one item is moved and `cnt_out` equals `cnt_in`.
- R9: With `rep_en`=1 and a nonzero count, `cnt_in` items are moved. The count drops by one after each write acknowledge and ends at 0.
- R10: With `rep_en`=1 and `cnt_in`=0, no handshake takes place. `done` pulses in the cycle after start, with pointer and count unchanged.
- R11: `done` is a one-cycle pulse and `busy` is 0 while it is high. `busy` is 1 from the cycle after an accepted start until the last write acknowledge. `ptr_out` and `cnt_out` hold the final values when `done` is high.
- R12: A `start` is accepted only while the block is idle. A start during a transfer or during the `done` cycle has no effect on the operation in flight or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opcode | input | 8 | Opcode; bit 0 selects byte or wider item |
| opsz32 | input | 1 | Operand-size attribute: 1 selects 32-bit, 0 selects 16-bit wide item |
| adsz32 | input | 1 | Address-size attribute: 1 selects 32-bit pointer, 0 selects 16-bit pointer |
| dir_down | input | 1 | Direction: 0 steps the pointer up, 1 steps it down |
| rep_en | input | 1 | Repeat mode using the count |
| port_addr | input | 16 | I/O port address |
| ptr_in | input | 32 | Starting destination pointer |
| cnt_in | input | 32 | Starting item count |
| io_rd_req | output | 1 | I/O read request |
| io_addr | output | 16 | I/O read port address |
| io_rd_ack | input | 1 | I/O read acknowledge (data valid) |
| io_rd_data | input | 32 | I/O read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data, zero-extended |
| mem_be | output | 4 | Memory byte enables |
| mem_wr_ack | input | 1 | Memory write acknowledge |
| busy | output | 1 | Items in flight |
| done | output | 1 | One-cycle completion pulse |
| ptr_out | output | 32 | Current or final pointer |
| cnt_out | output | 32 | Current or final count |

## Verification
Random operations mix all three item sizes, both directions, both address sizes, single and repeat modes, and counts from 0 to 5. Acknowledge delays on both handshakes are random. Each write is compared with a bench model, which separates mistakes in step size, step sign, wrap width and lane masking from one another. Directed cases cover the following:
- a 16-bit pointer that crosses 0xFFFF with a nonzero upper half, which tells a 16-bit wrap from a full carry;
- a 32-bit pointer that goes below zero;
- a zero count in repeat mode;
- a single-item run with a large count, which must leave the count alone.

A foreign start pulse with scrambled inputs is injected in the middle of every operation, so that any start which is not ignored changes the compared results.

// File: rtl/strin_pkg.sv
package strin_pkg;

    localparam int PORT_W = 16;
    localparam int DATA_W = 32;
    localparam int PTR_W  = 32;
    localparam int CNT_W  = 32;
    localparam int OPC_W  = 8;

    // Item size encoded as log2 of its byte count
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } item_sz_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_st_e;

    // Operation context captured when start is accepted
    typedef struct packed {
        item_sz_e          sz;
        logic              adr32;
        logic              down;
        logic              rep;
        logic [PORT_W-1:0] port;
    } op_ctx_t;

    function automatic logic [2:0] sz_bytes(item_sz_e s);
        return 3'd1 << s;
    endfunction

endpackage

// File: rtl/strin_decode.sv
module strin_decode
    import strin_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic [OW-1:0] opcode,
    input  logic          opsz32,
    output item_sz_e      sz
);
    always_comb begin
        if (!opcode[0])
            sz = SZ_BYTE;
        else if (opsz32)
            sz = SZ_DWORD;
        else
            sz = SZ_WORD;
    end
endmodule

// File: rtl/strin_ptr_unit.sv
module strin_ptr_unit
    import strin_pkg::*;
#(
    parameter int PW = PTR_W
) (
    input  logic [PW-1:0] ptr_cur,
    input  item_sz_e      sz,
    input  logic          down,
    input  logic          adr32,
    output logic [PW-1:0] ptr_nxt,
    output logic [PW-1:0] eff_addr
);
    localparam int HW = PW / 2;

    logic [PW-1:0] step;
    logic [PW-1:0] wide_nxt;
    logic [HW-1:0] low_nxt;

    always_comb begin
        step     = PW'(sz_bytes(sz));
        wide_nxt = down ? (ptr_cur - step) : (ptr_cur + step);
        low_nxt  = down ? (ptr_cur[HW-1:0] - step[HW-1:0])
                        : (ptr_cur[HW-1:0] + step[HW-1:0]);
        ptr_nxt  = adr32 ? wide_nxt : {ptr_cur[PW-1:HW], low_nxt};
        eff_addr = adr32 ? ptr_cur : {{(PW-HW){1'b0}}, ptr_cur[HW-1:0]};
    end
endmodule

// File: rtl/strin_lanes.sv
module strin_lanes
    import strin_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  item_sz_e        sz,
    input  logic [DW-1:0]   raw,
    output logic [DW-1:0]   packed_data,
    output logic [DW/8-1:0] be
);
    localparam int NL = DW / 8;

    logic [3:0] nbytes;
    assign nbytes = {1'b0, sz_bytes(sz)};

    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign be[i]                = (4'(i) < nbytes);
        assign packed_data[8*i +: 8] = be[i] ? raw[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/strin_ctrl.sv
module strin_ctrl
    import strin_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int CW = CNT_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  op_ctx_t       new_ctx,
    input  logic [PW-1:0] ptr_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          io_rd_ack,
    input  logic [DW-1:0] io_rd_data,
    input  logic          mem_wr_ack,
    input  logic [PW-1:0] ptr_next,
    output op_ctx_t       ctx,
    output logic [PW-1:0] ptr_q,
    output logic [CW-1:0] cnt_q,
    output logic [DW-1:0] data_q,
    output logic          io_rd_req,
    output logic          mem_wr_req,
    output logic          busy,
    output logic          done
);
    seq_st_e st;

    logic last_item;
    assign last_item = !ctx.rep || (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ctx    <= '0;
            ptr_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        ctx   <= new_ctx;
                        ptr_q <= ptr_in;
                        cnt_q <= cnt_in;
                        st    <= (new_ctx.rep && cnt_in == '0) ? ST_DONE : ST_READ;
                    end
                end
                ST_READ: begin
                    if (io_rd_ack) begin
                        data_q <= io_rd_data;
                        st     <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ack) begin
                        ptr_q <= ptr_next;
                        if (ctx.rep)
                            cnt_q <= cnt_q - CW'(1);
                        st <= last_item ? ST_DONE : ST_READ;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign io_rd_req  = (st == ST_READ);
    assign mem_wr_req = (st == ST_WRITE);
    assign busy       = (st == ST_READ) || (st == ST_WRITE);
    assign done       = (st == ST_DONE);

    // R3: a read request is held until it is acknowledged
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        io_rd_req && !io_rd_ack |=> io_rd_req);

    // R4: a write request is held until it is acknowledged
    p_wr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req && !mem_wr_ack |=> mem_wr_req);

    // R4: a write begins only right after a read acknowledge
    p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_req) |-> $past(io_rd_ack) && $past(io_rd_req));

    // R4: the two handshakes never overlap
    p_excl_req_r4: assert property (@(posedge clk) disable iff (rst)
        !(io_rd_req && mem_wr_req));

    // R9: in repeat mode each accepted write lowers the count by one
    p_cnt_dec_r9: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req && mem_wr_ack && ctx.rep |=> cnt_q == $past(cnt_q) - CW'(1));

    // R11: done lasts one cycle and never overlaps busy
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R12: captured context does not change while an operation is active
    p_ctx_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) && $past(st != ST_IDLE) |-> $stable(ctx));
endmodule

// File: rtl/strin_seq.sv
module strin_seq
    import strin_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = PORT_W,
    parameter int OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [OW-1:0] opcode,
    input  logic          opsz32,
    input  logic          adsz32,
    input  logic          dir_down,
    input  logic          rep_en,
    input  logic [AW-1:0] port_addr,
    input  logic [PW-1:0] ptr_in,
    input  logic [CW-1:0] cnt_in,
    output logic          io_rd_req,
    output logic [AW-1:0] io_addr,
    input  logic          io_rd_ack,
    input  logic [DW-1:0] io_rd_data,
    output logic          mem_wr_req,
    output logic [PW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW/8-1:0] mem_be,
    input  logic          mem_wr_ack,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] ptr_out,
    output logic [CW-1:0] cnt_out
);
    item_sz_e      dec_sz;
    op_ctx_t       new_ctx;
    op_ctx_t       ctx;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_next;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] data_q;

    strin_decode #(.OW(OW)) u_dec (
        .opcode (opcode),
        .opsz32 (opsz32),
        .sz     (dec_sz)
    );

    always_comb begin
        new_ctx.sz    = dec_sz;
        new_ctx.adr32 = adsz32;
        new_ctx.down  = dir_down;
        new_ctx.rep   = rep_en;
        new_ctx.port  = port_addr;
    end

    strin_ctrl #(.PW(PW), .CW(CW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .new_ctx    (new_ctx),
        .ptr_in     (ptr_in),
        .cnt_in     (cnt_in),
        .io_rd_ack  (io_rd_ack),
        .io_rd_data (io_rd_data),
        .mem_wr_ack (mem_wr_ack),
        .ptr_next   (ptr_next),
        .ctx        (ctx),
        .ptr_q      (ptr_q),
        .cnt_q      (cnt_q),
        .data_q     (data_q),
        .io_rd_req  (io_rd_req),
        .mem_wr_req (mem_wr_req),
        .busy       (busy),
        .done       (done)
    );

    strin_ptr_unit #(.PW(PW)) u_ptr (
        .ptr_cur  (ptr_q),
        .sz       (ctx.sz),
        .down     (ctx.down),
        .adr32    (ctx.adr32),
        .ptr_nxt  (ptr_next),
        .eff_addr (mem_addr)
    );

    strin_lanes #(.DW(DW)) u_lanes (
        .sz          (ctx.sz),
        .raw         (data_q),
        .packed_data (mem_wdata),
        .be          (mem_be)
    );

    assign io_addr = ctx.port;
    assign ptr_out = ptr_q;
    assign cnt_out = cnt_q;

    // R2: enabled lanes match the item size
    p_be_size_r2: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req |-> $countones(mem_be) == int'(sz_bytes(ctx.sz)));

    // R5: a 16-bit address never drives the upper address half
    p_addr16_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req && !ctx.adr32 |-> mem_addr[PW-1:PW/2] == '0);

    // R7: a 16-bit pointer step keeps the upper pointer half
    p_upper_keep_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req && mem_wr_ack && !ctx.adr32 |=> ptr_out[PW-1:PW/2] == $past(ptr_out[PW-1:PW/2]));
endmodule

// File: tb/sim_strin_seq.sv
module sim_strin_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h6C;
    logic        opsz32 = 1'b0, adsz32 = 1'b0, dir_down = 1'b0, rep_en = 1'b0;
    logic [15:0] port_addr = '0;
    logic [31:0] ptr_in = '0, cnt_in = '0;
    logic        io_rd_req, mem_wr_req, busy, done;
    logic [15:0] io_addr;
    logic        io_rd_ack = 1'b0, mem_wr_ack = 1'b0;
    logic [31:0] io_rd_data = '0;
    logic [31:0] mem_addr, mem_wdata, ptr_out, cnt_out;
    logic [3:0]  mem_be;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    strin_seq u0 (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .opsz32(opsz32),
        .adsz32(adsz32), .dir_down(dir_down), .rep_en(rep_en), .port_addr(port_addr),
        .ptr_in(ptr_in), .cnt_in(cnt_in), .io_rd_req(io_rd_req), .io_addr(io_addr),
        .io_rd_ack(io_rd_ack), .io_rd_data(io_rd_data), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_wr_ack(mem_wr_ack), .busy(busy), .done(done), .ptr_out(ptr_out),
        .cnt_out(cnt_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int f_size(input logic [7:0] opc, input bit o32);
        return !opc[0] ? 1 : (o32 ? 4 : 2);
    endfunction

    function automatic logic [31:0] f_step(input logic [31:0] p, input int sz, input bit dn, input bit a32);
        logic [31:0] w;
        logic [15:0] l;
        w = dn ? p - 32'(sz) : p + 32'(sz);
        l = dn ? p[15:0] - 16'(sz) : p[15:0] + 16'(sz);
        return a32 ? w : {p[31:16], l};
    endfunction

    function automatic logic [3:0] f_be(input int sz);
        return (sz == 1) ? 4'b0001 : (sz == 2) ? 4'b0011 : 4'b1111;
    endfunction

    function automatic logic [31:0] f_mask(input int sz);
        return (sz == 1) ? 32'h0000_00FF : (sz == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic run_op(input logic [7:0] opc, input bit o32, input bit a32, input bit dn,
                          input bit rp, input logic [15:0] port, input logic [31:0] p,
                          input logic [31:0] c);
        int sz, n, items, reads, cyc;
        bit fin;
        logic [31:0] ep, rd_val, exp_addr;
        sz = f_size(opc, o32);
        n = rp ? int'(c) : 1;
        ep = p; items = 0; reads = 0; cyc = 0; fin = 0; rd_val = '0;
        @(negedge clk);
        opcode = opc; opsz32 = o32; adsz32 = a32; dir_down = dn; rep_en = rp;
        port_addr = port; ptr_in = p; cnt_in = c; start = 1'b1;
        while (!fin && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            io_rd_ack = 1'b0;
            mem_wr_ack = 1'b0;
            start = (cyc == 3);
            if (cyc == 3) begin
                // foreign start with scrambled inputs, must be ignored (R12)
                ptr_in = ~p; cnt_in = c + 3; rep_en = ~rp; dir_down = ~dn;
                adsz32 = ~a32; opcode = opc ^ 8'h01; port_addr = port ^ 16'h5A5A;
            end
            if (cyc == 1 && n > 0)
                chk(busy === 1'b1, "R11 busy after start", 32'(busy), 32'd1);
            if (done) begin
                fin = 1;
                start = 1'b0;
                chk(busy === 1'b0, "R11 busy low at done", 32'(busy), 32'd0);
                chk(ptr_out === ep, "R6/R7 final pointer (R12)", ptr_out, ep);
                chk(cnt_out === (rp ? 32'd0 : c), rp ? "R9 final count" : "R8 count kept",
                    cnt_out, rp ? 32'd0 : c);
                chk(items == n, (n == 0) ? "R10 no transfer" : "R8/R9 item count",
                    32'(items), 32'(n));
                if (n == 0)
                    chk(cyc == 1, "R10 immediate done", 32'(cyc), 32'd1);
            end else begin
                if (io_rd_req && ($urandom % 3 == 0)) begin
                    io_rd_data = $urandom;
                    rd_val = io_rd_data;
                    io_rd_ack = 1'b1;
                    reads++;
                    chk(io_addr === port, "R3 port address", 32'(io_addr), 32'(port));
                end
                if (mem_wr_req && ($urandom % 3 == 0)) begin
                    exp_addr = a32 ? ep : {16'h0, ep[15:0]};
                    chk(mem_addr === exp_addr, "R5 write address", mem_addr, exp_addr);
                    chk(mem_wdata === (rd_val & f_mask(sz)), "R4 write data", mem_wdata, rd_val & f_mask(sz));
                    chk(mem_be === f_be(sz), "R2 byte enables", 32'(mem_be), 32'(f_be(sz)));
                    chk(reads == items + 1, "R4 read before write", 32'(reads), 32'(items + 1));
                    items++;
                    ep = f_step(ep, sz, dn, a32);
                    mem_wr_ack = 1'b1;
                end
            end
        end
        if (!fin)
            chk(1'b0, "R11 operation never finished", 32'(cyc), 32'd0);
        start = 1'b0;
        @(negedge clk);
        io_rd_ack = 1'b0;
        mem_wr_ack = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(io_rd_req === 1'b0, "R1 reset io_rd_req", 32'(io_rd_req), 32'd0);
        chk(mem_wr_req === 1'b0, "R1 reset mem_wr_req", 32'(mem_wr_req), 32'd0);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {30'd0, busy, done}, 32'd0);
        chk(ptr_out === 32'd0, "R1 reset ptr_out", ptr_out, 32'd0);
        chk(cnt_out === 32'd0, "R1 reset cnt_out", cnt_out, 32'd0);

        // R7: 16-bit wrap upward keeps upper half
        run_op(8'h6D, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0080, 32'hABCD_FFFE, 32'd3);
        // R7: 16-bit wrap downward
        run_op(8'h6D, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, 32'h1234_0002, 32'd2);
        // R7: 32-bit wrap downward
        run_op(8'h6D, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 32'h0000_0001, 32'd2);
        // R10: zero count in repeat mode
        run_op(8'h6C, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0060, 32'h0000_1000, 32'd0);
        // R8: single item, large count unchanged
        run_op(8'h6C, 1'b1, 1'b1, 1'b0, 1'b0, 16'h03F8, 32'h8000_0000, 32'hFFFF_FFFF);
        // R8: single item with zero count still moves one
        run_op(8'h6D, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1234, 32'h5555_0000, 32'd0);

        for (int k = 0; k < 80; k++) begin
            logic [7:0] opc;
            opc = ($urandom % 2 == 0) ? 8'h6C : 8'h6D;
            run_op(opc, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   16'($urandom), ($urandom % 4 == 0) ? 32'hFFFF_FFF0 + 32'($urandom % 32) : $urandom,
                   32'($urandom % 6));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule